// File: doc/BRIEF.md
# Word-Serial Timestamp Record Queue

This block buffers timestamp records captured for one traffic direction and hands them to a host one 16-bit word at a time through a single data register. A capture unit offers complete records on a valid/data input. Each record carries a tag, a 48-bit seconds value, a 32-bit nanoseconds value, a 64-bit clock identity, a port number and a sequence number. Records that are accepted go into a first-in first-out store holding up to 90 entries.

The host drains a record with twelve consecutive reads of the data register. A status word shows the capture enable, the position of the next word within the current record, and a saturating count of records lost to overflow. A not-empty flag and an interrupt-pending flag feed the shared buffer-status and interrupt-status registers. The pending flag is gated by a mask bit that comes from the shared mask register.

Top module: `ts_record_fifo`

## Requirements
- R1: A record is returned as 12 words, most significant word first within each field. Words 0 to 11 are: tag; seconds[47:32], [31:16], [15:0]; nanoseconds[31:16], [15:0]; clock identity[63:48], [47:32], [31:16], [15:0]; port number; sequence number.
- R2: The status word `stat_o` holds the enable in bit 15, the word position in bits 12:8 and the discard count in bits 7:4, with every other bit 0. All three fields are 0 after reset.
- R3: Each data read while the store is not empty advances the word position by one. The read of word 11 sets the position back to 0 and removes that record. A new record always starts at position 0.
- R4: A data read while the store is empty returns 0 on `data_o` and leaves the word position unchanged. `data_o` is also 0 whenever the store is empty.
- R5: The store holds 90 records. A record offered while 90 are held is dropped, even if a pop happens in the same cycle, and the stored records are unaffected.
- R6: Each dropped record raises the discard count by one, and the count saturates at 15.
- R7: A status write loads the enable from `stat_wen_i` and clears the discard count. The clear takes priority over a drop in the same cycle.
- R8: While the enable is 0, offered records are ignored: the store does not change and the discard count does not move.
- R9: `not_empty_o` is 1 exactly while at least one record is held.
- R10: `irq_pend_o` is set by an accepted record that enters an empty store and is cleared by `irq_clr_i`; a set in the same cycle wins. `irq_o` equals `irq_pend_o` AND `irq_mask_i`.
- R11: Records are read out in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record offered this cycle |
| rec_tag_i | input | 16 | Record tag |
| rec_sec_i | input | 48 | Seconds |
| rec_nsec_i | input | 32 | Nanoseconds |
| rec_clkid_i | input | 64 | Clock identity |
| rec_port_i | input | 16 | Port number |
| rec_seq_i | input | 16 | Sequence number |
| data_rd_i | input | 1 | Host read strobe of the data register |
| data_o | output | 16 | Current data word |
| stat_wr_i | input | 1 | Host write strobe of the status register |
| stat_wen_i | input | 1 | Enable value written with the status register |
| stat_o | output | 16 | Status word |
| irq_clr_i | input | 1 | Write-one-clear of the pending flag |
| irq_mask_i | input | 1 | Interrupt mask bit, 1 lets the flag through |
| not_empty_o | output | 1 | Store holds at least one record |
| irq_pend_o | output | 1 | Raw interrupt-pending flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
A slipped word position appears on the very next read as a word taken from the wrong field. The following pop then comes early or late, and every later record is shifted, so one wrong position shows within twelve reads. A wrong occupancy count appears as a missing or extra drop when the store reaches 90 records. It also shows as a `not_empty_o` that disagrees with the model one cycle after the event. Pointer errors show as records arriving out of order or with stale content at the first read of the affected entry.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned REC_WORDS = 12;
  localparam int unsigned REC_W     = WORD_W * REC_WORDS;
  localparam int unsigned POS_W     = 5;
  localparam int unsigned DISC_W    = 4;

  typedef struct packed {
    logic [15:0] tag;
    logic [47:0] sec;
    logic [31:0] nsec;
    logic [63:0] clkid;
    logic [15:0] port;
    logic [15:0] seq;
  } ts_rec_t;
endpackage

// File: rtl/ts_rec_store.sv
module ts_rec_store
  import ts_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 90
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  logic    pop_i,
  input  ts_rec_t wdata_i,
  output ts_rec_t rdata_o,
  output logic    full_o,
  output logic    empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  ts_rec_t          mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/ts_word_sel.sv
module ts_word_sel
  import ts_fifo_pkg::*;
(
  input  ts_rec_t           rec_i,
  input  logic [POS_W-1:0]  sel_i,
  input  logic              valid_i,
  output logic [WORD_W-1:0] word_o
);
  logic [REC_W-1:0]  flat;
  logic [WORD_W-1:0] words [REC_WORDS];

  assign flat = rec_i;

  for (genvar k = 0; k < REC_WORDS; k++) begin : g_word
    assign words[k] = flat[REC_W-1-k*WORD_W -: WORD_W];
  end

  always_comb begin
    word_o = '0;
    if (valid_i) begin
      for (int k = 0; k < REC_WORDS; k++) begin
        if (sel_i == POS_W'(k)) word_o = words[k];
      end
    end
  end
endmodule

// File: rtl/ts_rd_ctrl.sv
module ts_rd_ctrl
  import ts_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             empty_i,
  output logic [POS_W-1:0] pos_o,
  output logic             pop_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_WORDS - 1);

  logic [POS_W-1:0] pos_q;
  logic             step;

  assign step  = rd_i && !empty_i;
  assign pop_o = step && (pos_q == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (pop_o) pos_q <= '0;
    else if (step)  pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/ts_evt_ctrl.sv
module ts_evt_ctrl
  import ts_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic              full_i,
  input  logic              empty_i,
  input  logic              stat_wr_i,
  input  logic              stat_wen_i,
  input  logic              irq_clr_i,
  output logic              push_o,
  output logic              en_o,
  output logic [DISC_W-1:0] disc_o,
  output logic              irq_pend_o
);
  logic              en_q, irq_q, drop;
  logic [DISC_W-1:0] disc_q;

  assign push_o = rec_valid_i && en_q && !full_i;
  assign drop   = rec_valid_i && en_q && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      disc_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_wr_i) en_q <= stat_wen_i;
      // write clears and wins over a same-cycle drop
      if (stat_wr_i)                   disc_q <= '0;
      else if (drop && (~&disc_q))     disc_q <= disc_q + 1'b1;
      if (push_o && empty_i)           irq_q <= 1'b1;
      else if (irq_clr_i)              irq_q <= 1'b0;
    end
  end

  assign en_o       = en_q;
  assign disc_o     = disc_q;
  assign irq_pend_o = irq_q;
endmodule

// File: rtl/ts_record_fifo.sv
module ts_record_fifo
  import ts_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 90
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rec_valid_i,
  input  logic [15:0] rec_tag_i,
  input  logic [47:0] rec_sec_i,
  input  logic [31:0] rec_nsec_i,
  input  logic [63:0] rec_clkid_i,
  input  logic [15:0] rec_port_i,
  input  logic [15:0] rec_seq_i,
  input  logic        data_rd_i,
  output logic [15:0] data_o,
  input  logic        stat_wr_i,
  input  logic        stat_wen_i,
  output logic [15:0] stat_o,
  input  logic        irq_clr_i,
  input  logic        irq_mask_i,
  output logic        not_empty_o,
  output logic        irq_pend_o,
  output logic        irq_o
);
  ts_rec_t           wrec, rrec;
  logic              push, pop, full, empty, en;
  logic [POS_W-1:0]  pos;
  logic [DISC_W-1:0] disc;

  assign wrec = '{tag: rec_tag_i, sec: rec_sec_i, nsec: rec_nsec_i,
                  clkid: rec_clkid_i, port: rec_port_i, seq: rec_seq_i};

  ts_evt_ctrl u_evt (
    .clk_i, .rst_ni,
    .rec_valid_i, .full_i(full), .empty_i(empty),
    .stat_wr_i, .stat_wen_i, .irq_clr_i,
    .push_o(push), .en_o(en), .disc_o(disc), .irq_pend_o
  );

  ts_rec_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .wdata_i(wrec),
    .rdata_o(rrec), .full_o(full), .empty_o(empty)
  );

  ts_rd_ctrl u_rd (
    .clk_i, .rst_ni,
    .rd_i(data_rd_i), .empty_i(empty),
    .pos_o(pos), .pop_o(pop)
  );

  ts_word_sel u_sel (
    .rec_i(rrec), .sel_i(pos), .valid_i(!empty), .word_o(data_o)
  );

  assign stat_o      = {en, 2'b00, pos, disc, 4'b0000};
  assign not_empty_o = !empty;
  assign irq_o       = irq_pend_o && irq_mask_i;
endmodule

// File: rtl/ts_record_fifo_chk.sv
module ts_record_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rec_valid_i,
  input logic        data_rd_i,
  input logic [15:0] data_o,
  input logic        stat_wr_i,
  input logic [15:0] stat_o,
  input logic        irq_clr_i,
  input logic        irq_mask_i,
  input logic        not_empty_o,
  input logic        irq_pend_o,
  input logic        irq_o
);
  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[12:8] < 5'd12);                                               // R3
  AST_POS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && not_empty_o && stat_o[12:8] == 5'd11 |=> stat_o[12:8] == 5'd0); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_empty_o |-> data_o == 16'h0);                                   // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && !not_empty_o |=> $stable(stat_o[12:8]));                // R4
  AST_DISC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[7:4] == 4'hf && !stat_wr_i |=> stat_o[7:4] == 4'hf);          // R6
  AST_DISC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i |=> stat_o[7:4] == 4'h0);                                  // R7
  AST_DISABLED_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[15] && !stat_wr_i && !data_rd_i |=> $stable(not_empty_o) && $stable(stat_o[7:4])); // R8
  AST_STAT_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[14:13] == 2'b00 && stat_o[3:0] == 4'h0);                      // R2
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_pend_o && irq_mask_i));                                // R10
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !rec_valid_i |=> !irq_pend_o);                          // R10
endmodule

bind ts_record_fifo ts_record_fifo_chk u_chk (
  .clk_i, .rst_ni, .rec_valid_i, .data_rd_i, .data_o, .stat_wr_i, .stat_o,
  .irq_clr_i, .irq_mask_i, .not_empty_o, .irq_pend_o, .irq_o
);

// File: tb/ts_record_fifo_tb_top.sv
`timescale 1ns/1ps
module ts_record_fifo_tb_top;
  localparam int DEPTH = 90;
  localparam int NW    = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rec_valid_i = 0, data_rd_i = 0, stat_wr_i = 0, stat_wen_i = 0;
  logic irq_clr_i = 0, irq_mask_i = 0;
  logic [191:0] rec_bus = '0;
  logic [15:0] data_o, stat_o;
  logic not_empty_o, irq_pend_o, irq_o;

  always #5 clk_i = ~clk_i;

  ts_record_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .rec_valid_i,
    .rec_tag_i(rec_bus[191:176]), .rec_sec_i(rec_bus[175:128]),
    .rec_nsec_i(rec_bus[127:96]), .rec_clkid_i(rec_bus[95:32]),
    .rec_port_i(rec_bus[31:16]), .rec_seq_i(rec_bus[15:0]),
    .data_rd_i, .data_o, .stat_wr_i, .stat_wen_i, .stat_o,
    .irq_clr_i, .irq_mask_i, .not_empty_o, .irq_pend_o, .irq_o
  );

  int n_chk = 0, n_fail = 0;
  logic [191:0] mq[$];
  int  m_pos = 0, m_disc = 0;
  bit  m_en = 0, m_irq = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1 word order: field-major, MS word first, concatenated tag..seq
  function automatic logic [15:0] exp_word(logic [191:0] r, int k);
    return r[191-16*k -: 16];
  endfunction

  function automatic logic [15:0] exp_stat();
    return {m_en, 2'b00, 5'(m_pos), 4'(m_disc), 4'h0};
  endfunction

  function automatic logic [191:0] rnd_rec();
    return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic step(bit psh, logic [191:0] rec, bit rd, bit sw, bit swen, bit clr, bit msk);
    bit full_o, empty_o, drop, pushed;
    rec_valid_i = psh; rec_bus = rec; data_rd_i = rd;
    stat_wr_i = sw; stat_wen_i = swen; irq_clr_i = clr; irq_mask_i = msk;
    #1;
    if (mq.size() > 0) chk("R1 data word", 64'(data_o), 64'(exp_word(mq[0], m_pos)));
    else               chk("R4 empty data", 64'(data_o), 64'h0);
    chk("R10 masked irq", 64'(irq_o), 64'(m_irq & msk));
    @(negedge clk_i);
    rec_valid_i = 0; data_rd_i = 0; stat_wr_i = 0; irq_clr_i = 0;
    full_o = (mq.size() == DEPTH); empty_o = (mq.size() == 0);
    drop = psh && m_en && full_o;
    pushed = psh && m_en && !full_o;
    if (rd && !empty_o) begin
      if (m_pos == NW-1) begin void'(mq.pop_front()); m_pos = 0; end
      else m_pos++;
    end
    if (pushed) mq.push_back(rec);
    if (pushed && empty_o) m_irq = 1;
    else if (clr) m_irq = 0;
    if (sw) m_disc = 0;
    else if (drop && m_disc < 15) m_disc++;
    if (sw) m_en = swen;
    chk("R2 R3 R6 R7 status", 64'(stat_o), 64'(exp_stat()));
    chk("R9 not_empty", 64'(not_empty_o), 64'(mq.size() > 0));
    chk("R10 irq pending", 64'(irq_pend_o), 64'(m_irq));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [191:0] drec;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R2 reset state
    chk("R2 reset stat", 64'(stat_o), 64'h0);
    chk("R9 reset empty", 64'(not_empty_o), 64'h0);
    chk("R10 reset irq", 64'(irq_pend_o), 64'h0);
    // R8 disabled: record ignored
    step(1, rnd_rec(), 0, 0, 0, 0, 0);
    chk("R8 ignored while disabled", 64'(not_empty_o), 64'h0);
    // R7 enable write
    step(0, '0, 0, 1, 1, 0, 0);
    chk("R7 enable set", 64'(stat_o), 64'h8000);
    // R4 empty read keeps position
    step(0, '0, 1, 0, 0, 0, 0);
    chk("R4 empty read pos", 64'(stat_o[12:8]), 64'h0);
    // R10 irq on push into empty, mask gating, clear
    drec = {16'h0003, 48'h0000_1234_5678, 32'h3b9a_c9ff, 64'h0011_2233_4455_6677, 16'h0002, 16'hbeef};
    step(1, drec, 0, 0, 0, 0, 0);
    chk("R10 pending after push", 64'(irq_pend_o), 64'h1);
    step(0, '0, 0, 0, 0, 0, 1);
    step(0, '0, 0, 0, 0, 1, 1);
    chk("R10 cleared", 64'(irq_pend_o), 64'h0);
    // R1 R3 directed drain of 12 words
    for (int k = 0; k < NW; k++) step(0, '0, 1, 0, 0, 0, 0);
    chk("R3 record popped", 64'(not_empty_o), 64'h0);
    // R5 R6 fill, overflow, saturate
    for (int i = 0; i < DEPTH; i++) step(1, rnd_rec(), 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, rnd_rec(), 0, 0, 0, 0, 0);
    chk("R6 discard 3", 64'(stat_o[7:4]), 64'h3);
    for (int i = 0; i < 14; i++) step(1, rnd_rec(), 0, 0, 0, 0, 0);
    chk("R6 discard saturated", 64'(stat_o[7:4]), 64'hf);
    // R5 push during pop of last word while full: still dropped
    for (int k = 0; k < NW-1; k++) step(0, '0, 1, 0, 0, 0, 0);
    step(1, rnd_rec(), 1, 0, 0, 0, 0);
    chk("R5 full drop with pop", 64'(mq.size()), 64'(DEPTH-1));
    // R7 write clears count and wins over drop
    step(1, rnd_rec(), 0, 0, 0, 0, 0);
    step(1, rnd_rec(), 0, 1, 1, 0, 0);
    chk("R7 discard cleared", 64'(stat_o[7:4]), 64'h0);
    // R11 drain all in order
    while (mq.size() > 0) step(0, '0, 1, 0, 0, 0, 0);
    // random mixed traffic
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom_range(0, 99));
      step(r < 45, rnd_rec(), (r % 3) != 0, r == 7, r != 7 || ($urandom() & 1) == 1,
           r > 90, ($urandom() & 1) == 1);
    end
    finish_run();
  end
endmodule